// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of a small out-of-order machine whose functional units are not pipelined. Decoded instructions arrive one at a time. Each carries a unit kind, a function code, a destination register and two source registers. The controller tracks every accepted instruction through four steps: issue, operand read, execute and result write. For this it keeps one status record per functional unit and a table that names the unit that will write each register. It produces three things: an issue stall, a one-cycle operand-read/start strobe for each unit, and a one-hot grant for the single register-file write port.

There is no forwarding and no renaming. An instruction reads its operands only from the register file, and only after every producer it depends on has written back. A finished unit may not write back while an older instruction that has not yet read its operands still needs the old value of that register. Execution latency is outside the block. Each unit reports that it has finished with a pulse on its completion input. The datapath and the arithmetic are also outside the block.

Top module: `scoreboard_ctl`

## Requirements
- R1: After reset every unit is free, the table holds no pending writer, and `exec_start` and `wb_grant` are all zero.
- R2: Kind codes are 0 memory, 1 add, 2 multiply and 3 divide. Units are numbered memory first, then add, then multiply, then divide (by default 0, 1, 2 to 3, and 4). An instruction goes to the lowest-numbered free unit of its kind, and `issue_stall` rises in the same cycle when none is free.
- R3: `issue_stall` rises when the destination already has a pending writer. This holds even when that writer is granted write-back in the same cycle.
- R4: `issue_stall` is only ever high while `in_valid` is high. An instruction is accepted in any cycle in which `in_valid` is high and `issue_stall` is low. The source holds a stalled instruction, so nothing passes it.
- R5: A unit pulses `exec_start` for exactly one cycle, once both of its sources have no pending producer. The earliest such cycle is the one after issue. A source whose producer is granted write-back in the issue cycle counts as ready. A source that is waiting becomes ready in the cycle after its producer's grant.
- R6: A `unit_done` pulse has no effect unless that unit has started and has not yet finished.
- R7: A finished unit is held off write-back while another unit that has not started holds a source equal to its destination with that source marked ready.
- R8: Once a unit has pulsed `exec_start`, it no longer holds off any write-back.
- R9: At most one `wb_grant` bit is high in a cycle. Among the eligible units, the lowest-numbered one wins. `wb_dst` gives the destination of the granted unit.
- R10: A granted unit is free for a new issue in the next cycle. Its destination no longer counts as pending from that cycle on.
- R11: While a unit pulses `exec_start`, its `exec_func` slice (bits u*FW up to u*FW+FW-1) holds the function code it was issued with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Decoded instruction present |
| in_kind | input | 2 | Unit kind: 0 memory, 1 add, 2 multiply, 3 divide |
| in_func | input | FW | Function code kept in the unit record |
| in_dst | input | RW | Destination register |
| in_src1 | input | RW | First source register |
| in_src2 | input | RW | Second source register |
| unit_done | input | NU | Per-unit completion pulse |
| issue_stall | output | 1 | Instruction cannot be accepted this cycle |
| exec_start | output | NU | Per-unit operand read and execute start strobe |
| exec_func | output | NU*FW | Per-unit stored function code |
| wb_grant | output | NU | One-hot register write-back grant |
| wb_dst | output | RW | Destination register of the granted unit |

## Verification
The bench targets the same-cycle collisions, because an off-by-one in the bypass shows up there. One case is a source whose producer writes back in its issue cycle. A design that missed this would wait forever on a broadcast that already happened. Another case is a destination whose pending writer drains in the same cycle. Issue must still stall there; a design that let it through would clear the new table entry at once. The bench provokes write-after-read holds, where a design that checked the wrong ready flag would let a result overwrite a value not yet read. It also provokes multiply pairs that finish together, where the wrong priority would grant the higher unit. Spurious completion pulses reach waiting, idle and finished units. A design that honoured them would start or write back too early.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } stage_e;

  localparam logic [1:0] KIND_MEM = 2'd0;
  localparam logic [1:0] KIND_ADD = 2'd1;
  localparam logic [1:0] KIND_MUL = 2'd2;
  localparam logic [1:0] KIND_DIV = 2'd3;

  // Unit numbering: memory units first, then add, multiply, divide.
  function automatic logic [1:0] unit_kind(input int idx, input int n_mem,
                                           input int n_add, input int n_mul);
    if (idx < n_mem) return KIND_MEM;
    if (idx < n_mem + n_add) return KIND_ADD;
    if (idx < n_mem + n_add + n_mul) return KIND_MUL;
    return KIND_DIV;
  endfunction

endpackage

// File: rtl/sb_lowest.sv
module sb_lowest #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);

  assign gnt = req & (~req + 1'b1);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = i[IW-1:0];
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sb_regstat.sv
module sb_regstat #(
  parameter int NREG = 8,
  parameter int RW   = 3,
  parameter int UIW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_go,
  input  logic [RW-1:0]   set_reg,
  input  logic [UIW-1:0]  set_unit,
  input  logic            clr_go,
  input  logic [RW-1:0]   clr_reg,
  output logic [NREG-1:0] valid_o,
  output logic [UIW-1:0]  owner_o [NREG]
);

  logic [NREG-1:0] valid_q, valid_d;
  logic [UIW-1:0]  owner_q [NREG];

  always_comb begin
    valid_d = valid_q;
    if (clr_go) valid_d[clr_reg] = 1'b0;
    if (set_go) valid_d[set_reg] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (set_go) owner_q[set_reg] <= set_unit;
  end

  assign valid_o = valid_q;
  assign owner_o = owner_q;

endmodule

// File: rtl/sb_unit_rec.sv
module sb_unit_rec
  import sb_pkg::*;
#(
  parameter int RW  = 3,
  parameter int FW  = 4,
  parameter int UIW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_go,
  input  logic [FW-1:0]  iss_func,
  input  logic [RW-1:0]  iss_dst,
  input  logic [RW-1:0]  iss_src1,
  input  logic [RW-1:0]  iss_src2,
  input  logic           iss_q1v,
  input  logic [UIW-1:0] iss_q1,
  input  logic           iss_q2v,
  input  logic [UIW-1:0] iss_q2,
  input  logic           bc_valid,
  input  logic [UIW-1:0] bc_unit,
  input  logic           done_in,
  input  logic           wb_go,
  output stage_e         stage_o,
  output logic [RW-1:0]  fi_o,
  output logic [RW-1:0]  fj_o,
  output logic [RW-1:0]  fk_o,
  output logic           rj_o,
  output logic           rk_o,
  output logic [FW-1:0]  func_o,
  output logic           rd_req_o
);

  stage_e         stage_q, stage_d;
  logic           rj_q, rj_d, rk_q, rk_d;
  logic           qjv_q, qjv_d, qkv_q, qkv_d;
  logic [UIW-1:0] qj_q, qk_q;
  logic [RW-1:0]  fi_q, fj_q, fk_q;
  logic [FW-1:0]  func_q;
  logic           load_en;
  logic           rd_req;

  assign load_en = (stage_q == ST_IDLE) && issue_go;
  assign rd_req  = (stage_q == ST_WAIT) && rj_q && rk_q;

  always_comb begin
    stage_d = stage_q;
    rj_d    = rj_q;
    rk_d    = rk_q;
    qjv_d   = qjv_q;
    qkv_d   = qkv_q;
    case (stage_q)
      ST_IDLE: begin
        if (issue_go) begin
          stage_d = ST_WAIT;
          rj_d    = !iss_q1v;
          qjv_d   = iss_q1v;
          rk_d    = !iss_q2v;
          qkv_d   = iss_q2v;
        end
      end
      ST_WAIT: begin
        if (rd_req) begin
          stage_d = ST_EXEC;
          rj_d    = 1'b0;
          rk_d    = 1'b0;
        end else begin
          if (bc_valid && qjv_q && (qj_q == bc_unit)) begin
            rj_d  = 1'b1;
            qjv_d = 1'b0;
          end
          if (bc_valid && qkv_q && (qk_q == bc_unit)) begin
            rk_d  = 1'b1;
            qkv_d = 1'b0;
          end
        end
      end
      ST_EXEC: begin
        if (done_in) stage_d = ST_DONE;
      end
      ST_DONE: begin
        if (wb_go) stage_d = ST_IDLE;
      end
      default: stage_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      rj_q    <= 1'b0;
      rk_q    <= 1'b0;
      qjv_q   <= 1'b0;
      qkv_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      rj_q    <= rj_d;
      rk_q    <= rk_d;
      qjv_q   <= qjv_d;
      qkv_q   <= qkv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      fi_q   <= iss_dst;
      fj_q   <= iss_src1;
      fk_q   <= iss_src2;
      func_q <= iss_func;
      qj_q   <= iss_q1;
      qk_q   <= iss_q2;
    end
  end

  assign stage_o  = stage_q;
  assign fi_o     = fi_q;
  assign fj_o     = fj_q;
  assign fk_o     = fk_q;
  assign rj_o     = rj_q;
  assign rk_o     = rk_q;
  assign func_o   = func_q;
  assign rd_req_o = rd_req;

endmodule

// File: rtl/scoreboard_ctl.sv
module scoreboard_ctl
  import sb_pkg::*;
#(
  parameter int N_MEM = 1,
  parameter int N_ADD = 1,
  parameter int N_MUL = 2,
  parameter int N_DIV = 1,
  parameter int NREG  = 8,
  parameter int FW    = 4,
  localparam int NU   = N_MEM + N_ADD + N_MUL + N_DIV,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int UIW  = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic [FW-1:0]    in_func,
  input  logic [RW-1:0]    in_dst,
  input  logic [RW-1:0]    in_src1,
  input  logic [RW-1:0]    in_src2,
  input  logic [NU-1:0]    unit_done,
  output logic             issue_stall,
  output logic [NU-1:0]    exec_start,
  output logic [NU*FW-1:0] exec_func,
  output logic [NU-1:0]    wb_grant,
  output logic [RW-1:0]    wb_dst
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      srst_n <= rst_s1;
    end
  end

  stage_e         st     [NU];
  logic [RW-1:0]  fi     [NU];
  logic [RW-1:0]  fj     [NU];
  logic [RW-1:0]  fk     [NU];
  logic [FW-1:0]  func_a [NU];
  logic [NU-1:0]  rj_v, rk_v, rd_req, busy, fin, kmask, war, elig;
  logic [NU-1:0]  iss_cand, iss_gnt;
  logic           free_any;
  logic [UIW-1:0] iss_idx;
  logic           wb_any;
  logic [UIW-1:0] wb_idx;
  logic [NREG-1:0] rs_valid;
  logic [UIW-1:0]  rs_owner [NREG];
  logic           dst_pending, hazard, issue_go;
  logic           q1v, q2v;

  // issue: structural and WAW checks
  assign iss_cand    = kmask & ~busy;
  assign dst_pending = rs_valid[in_dst];
  assign hazard      = !free_any || dst_pending;
  assign issue_stall = in_valid && hazard;
  assign issue_go    = in_valid && !hazard;

  sb_lowest #(.N(NU), .IW(UIW)) u_iss_pick (
    .req (iss_cand),
    .gnt (iss_gnt),
    .any (free_any),
    .idx (iss_idx)
  );

  // a producer writing back this cycle no longer counts as pending
  assign q1v = rs_valid[in_src1] && !(wb_any && (rs_owner[in_src1] == wb_idx));
  assign q2v = rs_valid[in_src2] && !(wb_any && (rs_owner[in_src2] == wb_idx));

  for (genvar u = 0; u < NU; u++) begin : g_unit
    assign kmask[u] = (unit_kind(u, N_MEM, N_ADD, N_MUL) == in_kind);
    assign busy[u]  = (st[u] != ST_IDLE);
    assign fin[u]   = (st[u] == ST_DONE);
    assign exec_func[u*FW +: FW] = func_a[u];

    sb_unit_rec #(.RW(RW), .FW(FW), .UIW(UIW)) u_rec (
      .clk      (clk),
      .rst_n    (srst_n),
      .issue_go (issue_go && iss_gnt[u]),
      .iss_func (in_func),
      .iss_dst  (in_dst),
      .iss_src1 (in_src1),
      .iss_src2 (in_src2),
      .iss_q1v  (q1v),
      .iss_q1   (rs_owner[in_src1]),
      .iss_q2v  (q2v),
      .iss_q2   (rs_owner[in_src2]),
      .bc_valid (wb_any),
      .bc_unit  (wb_idx),
      .done_in  (unit_done[u]),
      .wb_go    (wb_grant[u]),
      .stage_o  (st[u]),
      .fi_o     (fi[u]),
      .fj_o     (fj[u]),
      .fk_o     (fk[u]),
      .rj_o     (rj_v[u]),
      .rk_o     (rk_v[u]),
      .func_o   (func_a[u]),
      .rd_req_o (rd_req[u])
    );
  end

  assign exec_start = rd_req;

  // WAR hold: an unstarted reader still needs the old register value
  always_comb begin
    war = '0;
    for (int u = 0; u < NU; u++) begin
      for (int v = 0; v < NU; v++) begin
        if ((v != u) && (st[v] == ST_WAIT) &&
            ((rj_v[v] && (fj[v] == fi[u])) || (rk_v[v] && (fk[v] == fi[u]))))
          war[u] = 1'b1;
      end
    end
  end

  assign elig = fin & ~war;

  sb_lowest #(.N(NU), .IW(UIW)) u_wb_pick (
    .req (elig),
    .gnt (wb_grant),
    .any (wb_any),
    .idx (wb_idx)
  );

  always_comb begin
    wb_dst = '0;
    for (int u = 0; u < NU; u++) begin
      if (wb_grant[u]) wb_dst = fi[u];
    end
  end

  sb_regstat #(.NREG(NREG), .RW(RW), .UIW(UIW)) u_regstat (
    .clk      (clk),
    .rst_n    (srst_n),
    .set_go   (issue_go),
    .set_reg  (in_dst),
    .set_unit (iss_idx),
    .clr_go   (wb_any),
    .clr_reg  (wb_dst),
    .valid_o  (rs_valid),
    .owner_o  (rs_owner)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NU = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          issue_stall,
  input logic          waw_hit,
  input logic [NU-1:0] exec_start,
  input logic [NU-1:0] wb_grant,
  input logic [NU-1:0] unit_busy
);

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant)); // R9

  AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall |-> in_valid); // R4

  AST_WAW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && waw_hit) |-> issue_stall); // R3

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_start != '0) |=> ((exec_start & $past(exec_start)) == '0)); // R5

  AST_FREE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_grant != '0) |=> ((unit_busy & $past(wb_grant)) == '0)); // R10

  AST_NO_START_AT_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_start & wb_grant) == '0); // R8

endmodule

bind scoreboard_ctl sb_checker #(.NU(NU)) u_chk (
  .clk         (clk),
  .rst_n       (srst_n),
  .in_valid    (in_valid),
  .issue_stall (issue_stall),
  .waw_hit     (dst_pending),
  .exec_start  (exec_start),
  .wb_grant    (wb_grant),
  .unit_busy   (busy)
);

// File: tb/sim_scoreboard_ctl.sv
module sim_scoreboard_ctl;
  localparam int NU = 5, NREG = 8, FW = 4, RW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             in_valid;
  logic [1:0]       in_kind;
  logic [FW-1:0]    in_func;
  logic [RW-1:0]    in_dst, in_src1, in_src2;
  logic [NU-1:0]    unit_done;
  logic             issue_stall;
  logic [NU-1:0]    exec_start, wb_grant;
  logic [NU*FW-1:0] exec_func;
  logic [RW-1:0]    wb_dst;

  scoreboard_ctl u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_func(in_func), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .unit_done(unit_done), .issue_stall(issue_stall), .exec_start(exec_start),
    .exec_func(exec_func), .wb_grant(wb_grant), .wb_dst(wb_dst)
  );

  // reference model: stage 0 idle, 1 waiting, 2 executing, 3 finished
  int m_stg [NU], m_fi [NU], m_fj [NU], m_fk [NU], m_func [NU];
  int m_qj [NU], m_qk [NU], m_cnt [NU];
  bit m_rj [NU], m_rk [NU], m_qjv [NU], m_qkv [NU];
  bit rs_v [NREG];
  int rs_o [NREG];
  int n_vec = 0, n_err = 0, cyc_no = 0;
  bit jitter = 1'b0, finished = 1'b0;

  function automatic int ukind(int u);
    if (u < 1) return 0;
    if (u < 2) return 1;
    if (u < 4) return 2;
    return 3;
  endfunction

  function automatic int base_lat(int k);
    case (k)
      0: return 3;
      1: return 2;
      2: return 6;
      default: return 10;
    endcase
  endfunction

  function automatic bit all_idle();
    for (int u = 0; u < NU; u++) if (m_stg[u] != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc_no);
    end
  endtask

  task automatic model_reset();
    for (int u = 0; u < NU; u++) begin
      m_stg[u] = 0; m_rj[u] = 0; m_rk[u] = 0; m_qjv[u] = 0; m_qkv[u] = 0; m_cnt[u] = 0;
    end
    for (int r = 0; r < NREG; r++) rs_v[r] = 0;
  endtask

  task automatic cyc(input bit v, input int k, input int f, input int d, input int s1,
                     input int s2, input bit [NU-1:0] spur, output bit stalled);
    bit [NU-1:0] dn, e_start, e_wb;
    int free, widx, lat;
    bit waw, e_stall, q1v, q2v, blk;
    string tag;
    @(negedge clk);
    cyc_no++;
    in_valid = v; in_kind = k[1:0]; in_func = f[FW-1:0];
    in_dst = d[RW-1:0]; in_src1 = s1[RW-1:0]; in_src2 = s2[RW-1:0];
    for (int u = 0; u < NU; u++)
      dn[u] = (m_stg[u] == 2 && m_cnt[u] == 1) || (spur[u] && m_stg[u] != 2);
    unit_done = dn;
    #1;
    free = -1;
    for (int u = 0; u < NU; u++) if (free < 0 && ukind(u) == k && m_stg[u] == 0) free = u;
    waw = rs_v[d];
    e_stall = v && (free < 0 || waw);
    e_wb = '0; widx = -1;
    for (int u = 0; u < NU; u++) begin
      e_start[u] = (m_stg[u] == 1) && m_rj[u] && m_rk[u];
      blk = 1'b0;
      for (int w = 0; w < NU; w++)
        if (w != u && m_stg[w] == 1 &&
            ((m_rj[w] && m_fj[w] == m_fi[u]) || (m_rk[w] && m_fk[w] == m_fi[u]))) blk = 1'b1;
      if (widx < 0 && m_stg[u] == 3 && !blk) begin widx = u; e_wb[u] = 1'b1; end
    end
    tag = !v ? "R4" : (waw ? "R3" : "R2");
    check({tag, "/R10"}, "issue_stall", int'(issue_stall), int'(e_stall));
    check("R5 R6", "exec_start", int'(exec_start), int'(e_start));
    check("R6 R7 R8 R9", "wb_grant", int'(wb_grant), int'(e_wb));
    if (widx >= 0) check("R9", "wb_dst", int'(wb_dst), m_fi[widx]);
    for (int u = 0; u < NU; u++)
      if (e_start[u]) check("R11", "exec_func", int'(exec_func[u*FW +: FW]), m_func[u]);
    stalled = e_stall;
    // model update for the coming edge
    q1v = 0; q2v = 0;
    if (v && !e_stall) begin
      q1v = rs_v[s1] && !(widx >= 0 && rs_o[s1] == widx);
      q2v = rs_v[s2] && !(widx >= 0 && rs_o[s2] == widx);
    end
    if (widx >= 0) begin
      m_stg[widx] = 0;
      rs_v[m_fi[widx]] = 0;
      for (int w = 0; w < NU; w++) if (m_stg[w] == 1) begin
        if (m_qjv[w] && m_qj[w] == widx) begin m_rj[w] = 1; m_qjv[w] = 0; end
        if (m_qkv[w] && m_qk[w] == widx) begin m_rk[w] = 1; m_qkv[w] = 0; end
      end
    end
    for (int u = 0; u < NU; u++) begin
      if (e_start[u]) begin
        lat = base_lat(ukind(u)) + (jitter ? int'($urandom % 4) - 1 : 0);
        if (lat < 1) lat = 1;
        m_stg[u] = 2; m_rj[u] = 0; m_rk[u] = 0; m_cnt[u] = lat;
      end else if (m_stg[u] == 2) begin
        if (dn[u]) m_stg[u] = 3;
        else m_cnt[u]--;
      end
    end
    if (v && !e_stall) begin
      m_stg[free] = 1; m_fi[free] = d; m_fj[free] = s1; m_fk[free] = s2; m_func[free] = f;
      m_qjv[free] = q1v; m_rj[free] = !q1v; m_qj[free] = rs_o[s1];
      m_qkv[free] = q2v; m_rk[free] = !q2v; m_qk[free] = rs_o[s2];
      rs_v[d] = 1; rs_o[d] = free;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit st, have;
    int k, f, d, s1, s2, t_start3, t_wb1;
    bit [NU-1:0] spur;
    void'($urandom(32'h5EED_0A17));
    rst_n = 1'b0; in_valid = 0; in_kind = 0; in_func = 0;
    in_dst = 0; in_src1 = 0; in_src2 = 0; unit_done = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "exec_start after reset", int'(exec_start), 0);
    check("R1", "wb_grant after reset", int'(wb_grant), 0);
    check("R1", "issue_stall after reset", int'(issue_stall), 0);

    // directed: structural, WAW, RAW and WAR
    cyc(1, 2, 5, 1, 2, 3, '0, st);          // multiply r1 -> unit 2
    check("R2", "first multiply accepted", int'(st), 0);
    cyc(1, 2, 6, 4, 1, 5, '0, st);          // multiply r4 waits on r1 -> unit 3
    check("R2", "second multiply to next unit", int'(st), 0);
    cyc(1, 2, 7, 6, 0, 0, '0, st);
    check("R2", "third multiply stalls", int'(st), 1);
    cyc(1, 1, 1, 1, 0, 0, '0, st);
    check("R3", "destination already pending", int'(st), 1);
    cyc(1, 1, 2, 5, 0, 0, 5'b01000, st);    // add writes r5, read by unit 3; spurious done on unit 3
    check("R4", "add accepted", int'(st), 0);
    t_start3 = -1; t_wb1 = -1;
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0, 0, 0, 0, 0, (i == 2) ? 5'b10000 : 5'b00000, st);
      if (exec_start[3] && t_start3 < 0) t_start3 = i;
      if (wb_grant[1] && t_wb1 < 0) t_wb1 = i;
    end
    check("R7", "add write held until reader starts", int'(t_wb1 > t_start3), 1);
    check("R8", "add write right after reader starts", t_wb1, t_start3 + 1);
    check("R6", "spurious done left units intact", int'(all_idle()), 1);

    // random, wide then narrow register range
    jitter = 1'b1; have = 0; k = 0; f = 0; d = 0; s1 = 0; s2 = 0;
    for (int c = 0; c < 4000; c++) begin
      int rmax;
      rmax = (c >= 2000) ? 3 : NREG;
      if (!have && ($urandom % 10) < 7) begin
        have = 1;
        k = int'($urandom % 4); f = int'($urandom % 16);
        d = int'($urandom % rmax); s1 = int'($urandom % rmax); s2 = int'($urandom % rmax);
      end
      for (int u = 0; u < NU; u++) spur[u] = (($urandom % 8) == 0);
      cyc(have, k, f, d, s1, s2, spur, st);
      if (have && !st) have = 0;
    end
    for (int i = 0; i < 400 && !all_idle(); i++) cyc(0, 0, 0, 0, 0, 0, '0, st);
    check("R10", "all units drained", int'(all_idle()), 1);
    cyc(0, 0, 0, 0, 0, 0, '0, st);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule